// File: doc/BRIEF.md
# Confirmed Threshold Fault Monitor

This block watches one redundant sensor lane. In every cycle it compares a signed sensor sample against a fixed threshold. A lane-enable mode bit gates the result. The gated condition must hold for an unbroken run of cycles before the block declares a fault. The fault is then stored in a set/reset element in which clearing always wins.

The stored fault drives the alarm output. Two further mode bits can raise the alarm directly:

- a force-set input loads the store;
- an override input forces the alarm for as long as it is held.

The compare flag, the confirmed flag and the store output are brought out so that the path that raised the alarm can be identified. All logic runs on one clock. A synchronous active-low reset empties the run counter and the store. The threshold, the sample width and the confirmation length are parameters.

Top module: `sensor_fault_monitor`

## Requirements
- R1: `over_thresh_o` is high in a cycle exactly when the signed `sample_i` is strictly greater than THRESH (default 2). A sample equal to THRESH does not qualify, and neither does a negative sample.
- R2: A cycle qualifies when `over_thresh_o` and `mode_enable_i` are both high. `confirmed_o` is high exactly when the current cycle and each of the previous CONFIRM_D cycles qualified, which is CONFIRM_D+1 (default 9) cycles in a row. One non-qualifying cycle restarts the run.
- R3: Qualifying cycles held during reset are not counted. `confirmed_o` stays low for the first CONFIRM_D cycles after reset is released and rises in cycle CONFIRM_D+1.
- R4: The store is set in a cycle where `mode_force_set_i` or `confirmed_o` is high. `latched_o` is high in that same cycle unless `mode_clear_i` is high.
- R5: `mode_clear_i` high forces `latched_o` low in that cycle, whatever set condition is present.
- R6: Once `latched_o` is high, it stays high in later cycles while `mode_clear_i` remains low, even after every set condition has gone.
- R7: `mode_override_i` high drives `alarm_o` high in that cycle, whatever the other inputs or the stored state.
- R8: `alarm_o` equals `mode_override_i` OR `latched_o`. With override low and the store empty, the alarm is low.
- R9: A reset empties the store and the run counter. After release, `latched_o` and `alarm_o` are low until a new set condition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | SAMPLE_W | Signed sensor sample |
| mode_enable_i | input | 1 | Lane-enable gate for the sensor path |
| mode_force_set_i | input | 1 | Sets the fault store directly |
| mode_clear_i | input | 1 | Clears the fault store; has priority over set |
| mode_override_i | input | 1 | Forces the alarm high |
| over_thresh_o | output | 1 | Sample exceeds the threshold this cycle |
| confirmed_o | output | 1 | Qualifying run has reached CONFIRM_D+1 cycles |
| latched_o | output | 1 | Fault store output |
| alarm_o | output | 1 | Confirmed-fault alarm |

## Verification
Two functions can act on the store in the same cycle: a set condition and the clear input. The bench provokes this in two ways. It drives force-set together with clear, and it holds clear high throughout a qualifying run, so that the confirmed flag rises while clear is asserted. In both cases the store output must stay low in that cycle and in the cycle after clear is released. The bench also raises override while clear is high; the alarm must then be high even though the store output is low.

// File: rtl/sfm_pkg.sv
// Package: shared types for the sensor fault monitor.
// Assumes: nothing beyond standard SystemVerilog.
package sfm_pkg;

    // Mode bits of one lane, grouped for internal routing.
    typedef struct packed {
        logic enable;
        logic force_set;
        logic clear;
        logic override;
    } lane_mode_t;

endpackage

// File: rtl/sfm_compare.sv
// Module: sfm_compare
// Does: flags a signed sample that lies strictly above a fixed threshold.
// Assumes: THRESH fits in SAMPLE_W signed bits.
module sfm_compare #(
    parameter int SAMPLE_W = 16,
    parameter int THRESH   = 2
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic                       over_o
);
    localparam logic signed [SAMPLE_W-1:0] THR = SAMPLE_W'(THRESH);

    // Purpose: signed strict compare.
    always_comb begin
        over_o = (sample_i > THR);
    end
endmodule

// File: rtl/sfm_confirm.sv
// Module: sfm_confirm
// Does: raises conf_o when qual_i has been high in the current cycle and in
//       each of the previous D cycles.
// Assumes: D >= 1. Reset is synchronous and active low.
module sfm_confirm #(
    parameter int D = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    output logic conf_o
);
    localparam int CW = $clog2(D + 1);
    localparam logic [CW-1:0] CMAX = CW'(D);

    // Length of the qualifying run in previous cycles, saturating at D.
    logic [CW-1:0] run_q;

    // Purpose: count the run of qualifying cycles; clear on a miss or on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= '0;
        else if (!qual_i)        run_q <= '0;
        else if (run_q != CMAX)  run_q <= run_q + 1'b1;
    end

    // Purpose: the current cycle plus D earlier cycles all qualify.
    always_comb begin
        conf_o = qual_i && (run_q == CMAX);
    end

    // R2: the confirmed flag never stands without a qualifying cycle.
    p_conf_needs_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conf_o |-> qual_i);
    // R2, R3: the confirmed flag also needs the previous cycle to qualify.
    p_conf_needs_prev_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_o && $past(rst_n)) |-> $past(qual_i));
    // R2: the run counter never passes its limit.
    p_run_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CMAX);
endmodule

// File: rtl/sfm_latch.sv
// Module: sfm_latch
// Does: a set/reset store in which clear wins. The output is combinational
//       in the current cycle: q = (set | q_prev) & ~clear.
// Assumes: reset is synchronous and active low.
module sfm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic held_q;

    // Purpose: current-cycle store output, with clear taking priority.
    always_comb begin
        q_o = (set_i || held_q) && !clr_i;
    end

    // Purpose: keep the store value for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= q_o;
    end

    // R5: clear forces the store output low.
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> !q_o);
    // R4: a set without clear shows at once.
    p_set_shows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |-> q_o);
    // R6: the stored value holds while clear stays low.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && $past(q_o) && $past(rst_n)) |-> q_o);
endmodule

// File: rtl/sensor_fault_monitor.sv
// Module: sensor_fault_monitor (top)
// Does: compares a sample with a threshold, gates the result with the lane
//       enable, confirms it over CONFIRM_D+1 cycles, stores the fault in a
//       clear-dominant store and drives the alarm. The override input forces
//       the alarm.
// Assumes: a single clock; synchronous active-low reset; CONFIRM_D >= 1.
module sensor_fault_monitor #(
    parameter int SAMPLE_W  = 16,
    parameter int THRESH    = 2,
    parameter int CONFIRM_D = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic                       mode_enable_i,
    input  logic                       mode_force_set_i,
    input  logic                       mode_clear_i,
    input  logic                       mode_override_i,
    output logic                       over_thresh_o,
    output logic                       confirmed_o,
    output logic                       latched_o,
    output logic                       alarm_o
);
    import sfm_pkg::*;

    lane_mode_t mode;
    logic       qual;
    logic       store_set;

    // Purpose: group the mode bits.
    always_comb begin
        mode.enable    = mode_enable_i;
        mode.force_set = mode_force_set_i;
        mode.clear     = mode_clear_i;
        mode.override  = mode_override_i;
    end

    sfm_compare #(.SAMPLE_W(SAMPLE_W), .THRESH(THRESH)) i_cmp (
        .sample_i (sample_i),
        .over_o   (over_thresh_o)
    );

    // Purpose: gate the compare result with the lane enable.
    always_comb begin
        qual = over_thresh_o && mode.enable;
    end

    sfm_confirm #(.D(CONFIRM_D)) i_conf (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual_i (qual),
        .conf_o (confirmed_o)
    );

    // Purpose: the store is set directly or by a confirmed fault.
    always_comb begin
        store_set = mode.force_set || confirmed_o;
    end

    sfm_latch i_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (store_set),
        .clr_i (mode.clear),
        .q_o   (latched_o)
    );

    // Purpose: the alarm comes from the override or from the store.
    always_comb begin
        alarm_o = mode.override || latched_o;
    end

    // R7: the override always raises the alarm.
    p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_override_i |-> alarm_o);
    // R8: with no override and an empty store, the alarm is low.
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_override_i && !latched_o) |-> !alarm_o);
    // R2: a disabled lane cannot confirm a fault.
    p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_enable_i |-> !confirmed_o);
endmodule

// File: tb/test_sensor_fault_monitor.sv
// Directed bench for sensor_fault_monitor. Inputs change at the falling
// edge; outputs are sampled 1 ns later, away from the rising edge.
module test_sensor_fault_monitor;
    localparam int W = 16;
    localparam int D = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [W-1:0] sample = '0;
    logic en = 0, fs = 0, clr = 0, ov = 0;
    logic over, conf, lat, alarm;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    sensor_fault_monitor #(.SAMPLE_W(W), .THRESH(2), .CONFIRM_D(D)) i_sensor_fault_monitor (
        .clk(clk), .rst_n(rst_n), .sample_i(sample),
        .mode_enable_i(en), .mode_force_set_i(fs),
        .mode_clear_i(clr), .mode_override_i(ov),
        .over_thresh_o(over), .confirmed_o(conf),
        .latched_o(lat), .alarm_o(alarm)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Apply inputs at the falling edge, then settle 1 ns.
    task automatic drive(input int s, input logic e, input logic f,
                         input logic c, input logic o);
        @(negedge clk);
        sample = W'(s); en = e; fs = f; clr = c; ov = o;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset_state();
        do_reset();
        drive(0, 0, 0, 0, 0);
        chk(over, 0, "R9 over after reset");
        chk(conf, 0, "R9 confirmed after reset");
        chk(lat, 0, "R9 latched after reset");
        chk(alarm, 0, "R9 alarm after reset");
    endtask

    task automatic t_compare();
        drive(2, 0, 0, 0, 0);       chk(over, 0, "R1 equal to threshold");
        drive(3, 0, 0, 0, 0);       chk(over, 1, "R1 threshold+1");
        drive(-5, 0, 0, 0, 0);      chk(over, 0, "R1 negative");
        drive(32767, 0, 0, 0, 0);   chk(over, 1, "R1 max positive");
        drive(-32768, 0, 0, 0, 0);  chk(over, 0, "R1 min negative");
    endtask

    // Qualifying run that starts while reset is still asserted.
    task automatic t_confirm_run();
        @(negedge clk); rst_n = 0; sample = 5; en = 1; fs = 0; clr = 0; ov = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        for (int k = 1; k <= D + 1; k++) begin
            chk(conf, (k == D + 1), $sformatf("R3 confirmed in cycle %0d", k));
            if (k <= D) drive(5, 1, 0, 0, 0);
        end
        chk(lat, 1, "R4 latched on confirm");
        chk(alarm, 1, "R8 alarm from store");
        drive(2, 1, 0, 0, 0);
        chk(conf, 0, "R2 miss drops confirmed");
        chk(lat, 1, "R6 store holds after miss");
        drive(5, 1, 0, 0, 0);
        chk(conf, 0, "R2 run restarts after miss");
        chk(alarm, 1, "R6 alarm still held");
        drive(0, 0, 0, 1, 0);
        chk(lat, 0, "R5 clear empties store");
        chk(alarm, 0, "R8 alarm low after clear");
        drive(0, 0, 0, 0, 0);
        chk(lat, 0, "R6 store stays empty");
    endtask

    task automatic t_enable_gate();
        do_reset();
        for (int k = 0; k < D + 4; k++) drive(7, 0, 0, 0, 0);
        chk(conf, 0, "R2 disabled lane does not confirm");
        chk(alarm, 0, "R2 disabled lane gives no alarm");
    endtask

    task automatic t_force_set();
        do_reset();
        drive(0, 0, 1, 0, 0);
        chk(lat, 1, "R4 force-set latches");
        chk(alarm, 1, "R4 force-set alarm");
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        chk(lat, 1, "R6 hold after force-set released");
        drive(0, 0, 0, 1, 0);
        chk(lat, 0, "R5 clear after force-set");
    endtask

    task automatic t_clear_wins();
        do_reset();
        drive(0, 0, 1, 1, 0);
        chk(lat, 0, "R5 set and clear in the same cycle");
        chk(alarm, 0, "R5 alarm low when clear wins");
        drive(0, 0, 0, 0, 0);
        chk(lat, 0, "R5 nothing stored after clear won");
        for (int k = 0; k < D + 1; k++) drive(9, 1, 0, 1, 0);
        chk(conf, 1, "R5 confirmed reached during clear");
        chk(lat, 0, "R5 clear beats confirmed set");
        drive(0, 0, 0, 0, 0);
        chk(lat, 0, "R5 nothing stored after confirm under clear");
    endtask

    task automatic t_override();
        do_reset();
        drive(0, 0, 0, 1, 1);
        chk(alarm, 1, "R7 override with clear high");
        chk(lat, 0, "R7 override does not load store");
        drive(-3, 0, 0, 0, 1);
        chk(alarm, 1, "R7 override alone");
        drive(0, 0, 0, 0, 0);
        chk(alarm, 0, "R8 alarm low after override removed");
    endtask

    task automatic t_reset_clears();
        do_reset();
        drive(0, 0, 1, 0, 0);
        chk(lat, 1, "R9 pre-reset store set");
        drive(5, 1, 0, 0, 0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        sample = 5; en = 1;
        #1;
        chk(lat, 0, "R9 store emptied by reset");
        chk(alarm, 0, "R9 alarm low after reset");
        chk(conf, 0, "R9 run counter emptied by reset");
    endtask

    initial begin
        t_reset_state();
        t_compare();
        t_confirm_run();
        t_enable_gate();
        t_force_set();
        t_clear_wins();
        t_override();
        t_reset_clears();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule